// File: doc/BRIEF.md
# Flat Control Decoder with Logical Shift Path

This block is the instruction control stage of a 32-bit single-cycle processor core. It supports ten operations: five register-register ALU operations, load word, store word, branch-if-equal, and the two logical shifts by an immediate count. A single flat lookup on the primary opcode and the function field produces the complete control word in one combinational step. There is no separate ALU-operation decoder level.

The block also holds the barrel shifter that the two shift instructions use, and the result multiplexer that passes either the shifter output or the ALU result toward writeback. The shifter takes the register read through the port addressed by instruction bits 20..16. It shifts that value by the 5-bit count taken from instruction bits 10..6. The register file, the memories and the program-counter logic sit outside this block. They consume the control word and the selected result.

Top module: `shift_ctl_top`

## Requirements
- R1: For opcode 000000 with function 100000, 100010, 100100, 100101 or 101010, the outputs are reg_write=1, reg_dst=1 and alu_src=0, with alu_ctl equal to 010, 110, 000, 001 or 111 respectively. branch, mem_write, mem_to_reg, shift_sel and shift_left are all 0.
- R2: For opcode 100011 (load word), the outputs are reg_write=1, reg_dst=0, alu_src=1, alu_ctl=010, mem_to_reg=1, and branch=mem_write=shift_sel=shift_left=0.
- R3: For opcode 101011 (store word), the outputs are mem_write=1, alu_src=1 and alu_ctl=010. reg_write, branch, shift_sel and shift_left are 0, and the don't-cares reg_dst and mem_to_reg are driven to 0.
- R4: For opcode 000100 (branch if equal), the outputs are branch=1, alu_ctl=110 and alu_src=0. reg_write, mem_write, shift_sel and shift_left are 0, and reg_dst and mem_to_reg are driven to 0.
- R5: For opcode 000000 with function 000000 (shift left), the outputs are reg_write=1, reg_dst=1, alu_src=0, alu_ctl=010, shift_sel=1 and shift_left=1, with branch=mem_write=mem_to_reg=0.
- R6: For opcode 000000 with function 000010 (shift right), the control word is the same as in R5 except that shift_left=0.
- R7: When shifting left, result equals the source value shifted left by shamt, with the vacated low bits filled with zeros.
- R8: When shifting right, result equals the source value logically shifted right by shamt, with the vacated high bits filled with zeros.
- R9: For every instruction that is not a shift, shift_sel=0, shift_left=0, and result equals alu_res_i unchanged, whatever the values of shamt and the source.
- R10: Any other opcode, or opcode 000000 with any other function code, drives every control output to 0, so nothing is written or branched. result then equals alu_res_i.
- R11: A shift with shamt=0 returns the source value unchanged, and shamt=31 keeps only one source bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 6 | Instruction bits 31..26 |
| funct_i | input | 6 | Instruction bits 5..0 |
| shamt_i | input | 5 | Shift count, instruction bits 10..6 |
| src_val_i | input | 32 | Register value read through the bits 20..16 port |
| alu_res_i | input | 32 | ALU result |
| reg_write_o | output | 1 | Register file write enable |
| reg_dst_o | output | 1 | Destination from bits 15..11 when 1, from bits 20..16 when 0 |
| alu_src_o | output | 1 | ALU second operand is the extended immediate |
| alu_ctl_o | output | 3 | ALU operation code |
| branch_o | output | 1 | Conditional branch instruction |
| mem_write_o | output | 1 | Data memory write enable |
| mem_to_reg_o | output | 1 | Writeback takes memory read data |
| shift_left_o | output | 1 | Shifter direction: 1 left, 0 right |
| shift_sel_o | output | 1 | Result comes from the shifter |
| result_o | output | 32 | Shifter output or ALU result, as chosen by shift_sel_o |

## Verification
The bench aims at the boundaries of the shift count: zero, one, 31 and mixed values. A stage wired to the wrong count bit, or a right shift that carries the sign bit, would corrupt the high or low bits that these vectors check. It also puts sll at function 000000 beside unknown R-type functions and unknown opcodes. A decoder that treats an all-zero function as "anything else", or that leaves a write enable high for an undefined encoding, would show a non-zero control word there. Non-shift instructions are sent with non-zero shamt and random source values, so a result mux that leaks the shifter output shows up as a result that differs from the ALU input.

// File: rtl/shift_ctl_pkg.sv
package shift_ctl_pkg;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LOAD  = 6'b100011;
  localparam logic [5:0] OP_STORE = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;
  localparam logic [5:0] FN_SHL = 6'b000000;
  localparam logic [5:0] FN_SHR = 6'b000010;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  typedef struct packed {
    logic    reg_write;
    logic    reg_dst;
    logic    alu_src;
    alu_op_e alu_ctl;
    logic    branch;
    logic    mem_write;
    logic    mem_to_reg;
    logic    shift_left;
    logic    shift_sel;
  } ctl_word_t;

  localparam ctl_word_t CTL_NONE = '{
    reg_write: 1'b0, reg_dst: 1'b0, alu_src: 1'b0, alu_ctl: ALU_AND,
    branch: 1'b0, mem_write: 1'b0, mem_to_reg: 1'b0,
    shift_left: 1'b0, shift_sel: 1'b0
  };

endpackage

// File: rtl/shift_ctl_decode.sv
module shift_ctl_decode
  import shift_ctl_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  output ctl_word_t  ctl_o
);

  ctl_word_t rtype_w;

  // Register-register rows, selected by the function field.
  always_comb begin
    rtype_w           = CTL_NONE;
    rtype_w.reg_write = 1'b1;
    rtype_w.reg_dst   = 1'b1;
    unique case (funct_i)
      FN_ADD:  rtype_w.alu_ctl = ALU_ADD;
      FN_SUB:  rtype_w.alu_ctl = ALU_SUB;
      FN_AND:  rtype_w.alu_ctl = ALU_AND;
      FN_OR:   rtype_w.alu_ctl = ALU_OR;
      FN_SLT:  rtype_w.alu_ctl = ALU_SLT;
      FN_SHL: begin
        rtype_w.alu_ctl    = ALU_ADD;
        rtype_w.shift_sel  = 1'b1;
        rtype_w.shift_left = 1'b1;
      end
      FN_SHR: begin
        rtype_w.alu_ctl   = ALU_ADD;
        rtype_w.shift_sel = 1'b1;
      end
      default: rtype_w = CTL_NONE;
    endcase
  end

  always_comb begin
    ctl_o = CTL_NONE;
    unique case (opcode_i)
      OP_RTYPE: ctl_o = rtype_w;
      OP_LOAD: begin
        ctl_o.reg_write  = 1'b1;
        ctl_o.alu_src    = 1'b1;
        ctl_o.alu_ctl    = ALU_ADD;
        ctl_o.mem_to_reg = 1'b1;
      end
      OP_STORE: begin
        ctl_o.mem_write = 1'b1;
        ctl_o.alu_src   = 1'b1;
        ctl_o.alu_ctl   = ALU_ADD;
      end
      OP_BEQ: begin
        ctl_o.branch  = 1'b1;
        ctl_o.alu_ctl = ALU_SUB;
      end
      default: ctl_o = CTL_NONE;
    endcase
  end

  always_comb begin
    // R5
    shift_row_chk: assert (!ctl_o.shift_sel ||
      (ctl_o.reg_write && ctl_o.reg_dst && !ctl_o.mem_write &&
       !ctl_o.branch && !ctl_o.mem_to_reg && !ctl_o.alu_src));
    // R9
    dir_gate_chk: assert (!ctl_o.shift_left || ctl_o.shift_sel);
    // R10
    excl_path_chk: assert ($onehot0({ctl_o.mem_to_reg, ctl_o.mem_write,
                                     ctl_o.branch, ctl_o.shift_sel}));
    // R3
    store_nowrite_chk: assert (!ctl_o.mem_write || !ctl_o.reg_write);
  end

endmodule

// File: rtl/shift_ctl_barrel.sv
module shift_ctl_barrel #(
  parameter int WIDTH = 32,
  localparam int CNT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] din_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             left_i,
  output logic [WIDTH-1:0] dout_o
);

  logic [WIDTH-1:0] stage [0:CNT_W];

  assign stage[0] = din_i;

  for (genvar k = 0; k < CNT_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    logic [WIDTH-1:0] moved;
    always_comb begin
      if (left_i) moved = stage[k] << STEP;
      else        moved = stage[k] >> STEP;
    end
    assign stage[k+1] = cnt_i[k] ? moved : stage[k];
  end

  assign dout_o = stage[CNT_W];

  always_comb begin
    // R11
    zero_count_chk: assert (cnt_i != '0 || dout_o == din_i);
    // R7
    left_fill_chk: assert (!left_i || cnt_i == '0 || !dout_o[0]);
    // R8
    right_fill_chk: assert (left_i || cnt_i == '0 || !dout_o[WIDTH-1]);
  end

endmodule

// File: rtl/shift_ctl_resmux.sv
module shift_ctl_resmux #(
  parameter int WIDTH = 32
) (
  input  logic             sel_shift_i,
  input  logic [WIDTH-1:0] shift_i,
  input  logic [WIDTH-1:0] alu_i,
  output logic [WIDTH-1:0] res_o
);

  always_comb begin
    if (sel_shift_i) res_o = shift_i;
    else             res_o = alu_i;
  end

  always_comb begin
    // R9
    alu_pass_chk: assert (sel_shift_i || res_o == alu_i);
  end

endmodule

// File: rtl/shift_ctl_top.sv
module shift_ctl_top
  import shift_ctl_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [5:0]         opcode_i,
  input  logic [5:0]         funct_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic [DATA_W-1:0]  src_val_i,
  input  logic [DATA_W-1:0]  alu_res_i,
  output logic               reg_write_o,
  output logic               reg_dst_o,
  output logic               alu_src_o,
  output logic [2:0]         alu_ctl_o,
  output logic               branch_o,
  output logic               mem_write_o,
  output logic               mem_to_reg_o,
  output logic               shift_left_o,
  output logic               shift_sel_o,
  output logic [DATA_W-1:0]  result_o
);

  ctl_word_t         ctl_w;
  logic [DATA_W-1:0] shifted_w;

  shift_ctl_decode u_decode (
    .opcode_i (opcode_i),
    .funct_i  (funct_i),
    .ctl_o    (ctl_w)
  );

  shift_ctl_barrel #(.WIDTH(DATA_W)) u_barrel (
    .din_i  (src_val_i),
    .cnt_i  (shamt_i),
    .left_i (ctl_w.shift_left),
    .dout_o (shifted_w)
  );

  shift_ctl_resmux #(.WIDTH(DATA_W)) u_resmux (
    .sel_shift_i (ctl_w.shift_sel),
    .shift_i     (shifted_w),
    .alu_i       (alu_res_i),
    .res_o       (result_o)
  );

  assign reg_write_o  = ctl_w.reg_write;
  assign reg_dst_o    = ctl_w.reg_dst;
  assign alu_src_o    = ctl_w.alu_src;
  assign alu_ctl_o    = ctl_w.alu_ctl;
  assign branch_o     = ctl_w.branch;
  assign mem_write_o  = ctl_w.mem_write;
  assign mem_to_reg_o = ctl_w.mem_to_reg;
  assign shift_left_o = ctl_w.shift_left;
  assign shift_sel_o  = ctl_w.shift_sel;

endmodule

// File: tb/test_shift_ctl_top.sv
module test_shift_ctl_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  opcode, funct;
  logic [4:0]  shamt;
  logic [31:0] src, alu;
  logic        rw, rd, as, br, mw, m2r, sl, ss;
  logic [2:0]  actl;
  logic [31:0] res;
  int          n_vec = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  shift_ctl_top i_shift_ctl_top (
    .opcode_i(opcode), .funct_i(funct), .shamt_i(shamt),
    .src_val_i(src), .alu_res_i(alu),
    .reg_write_o(rw), .reg_dst_o(rd), .alu_src_o(as), .alu_ctl_o(actl),
    .branch_o(br), .mem_write_o(mw), .mem_to_reg_o(m2r),
    .shift_left_o(sl), .shift_sel_o(ss), .result_o(res)
  );

  // Behavioural reference: {rw,rd,as,ctl[2:0],br,mw,m2r,left,sel,result[31:0]}
  function automatic logic [43:0] expect_of(input logic [5:0] op,
      input logic [5:0] fn, input logic [4:0] sh,
      input logic [31:0] s, input logic [31:0] a);
    logic [11:0] c = 12'b0;
    logic [31:0] r = a;
    if (op == 6'd0) begin
      if      (fn == 6'h20) c = 12'b110_010_000_00;
      else if (fn == 6'h22) c = 12'b110_110_000_00;
      else if (fn == 6'h24) c = 12'b110_000_000_00;
      else if (fn == 6'h25) c = 12'b110_001_000_00;
      else if (fn == 6'h2a) c = 12'b110_111_000_00;
      else if (fn == 6'h00) begin c = 12'b110_010_000_11; r = s << sh; end
      else if (fn == 6'h02) begin c = 12'b110_010_000_01; r = s >> sh; end
    end
    else if (op == 6'h23) c = 12'b101_010_001_00;
    else if (op == 6'h2b) c = 12'b001_010_010_00;
    else if (op == 6'h04) c = 12'b000_110_100_00;
    return {c, r};
  endfunction

  task automatic apply(input logic [5:0] op, input logic [5:0] fn,
      input logic [4:0] sh, input logic [31:0] s, input logic [31:0] a,
      input string req);
    logic [43:0] exp_v, act_v;
    @(posedge clk);
    opcode = op; funct = fn; shamt = sh; src = s; alu = a;
    @(negedge clk);
    exp_v = expect_of(op, fn, sh, s, a);
    act_v = {rw, rd, as, actl, br, mw, m2r, sl, ss, res};
    n_vec++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s op=%b fn=%b sh=%0d actual=%h expected=%h",
               req, op, fn, sh, act_v, exp_v);
    end
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    opcode = 6'h3f; funct = 6'h3f; shamt = '0; src = '0; alu = 32'h1234_5678;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R10 idle encoding before any real instruction
    apply(6'h3f, 6'h3f, 5'd0, 32'h0, 32'h1234_5678, "R10");
    // R1 each ALU function, with nonzero shamt to probe leakage (R9)
    apply(6'h00, 6'h20, 5'd7, 32'hdead_beef, 32'h0000_0011, "R1");
    apply(6'h00, 6'h22, 5'd3, 32'h8000_0001, 32'hffff_fff0, "R1");
    apply(6'h00, 6'h24, 5'd31, 32'hffff_ffff, 32'h0505_0505, "R1");
    apply(6'h00, 6'h25, 5'd1, 32'h1, 32'h7777_0000, "R1");
    apply(6'h00, 6'h2a, 5'd16, 32'h0f0f_0f0f, 32'h0000_0001, "R1");
    // R2 R3 R4 memory and branch rows, R9 result pass-through
    apply(6'h23, 6'h00, 5'd5, 32'haaaa_5555, 32'h7fff_feb8, "R2");
    apply(6'h2b, 6'h02, 5'd9, 32'h1111_2222, 32'h1000_0004, "R3");
    apply(6'h04, 6'h00, 5'd2, 32'hcafe_f00d, 32'h0, "R4");
    apply(6'h04, 6'h02, 5'd30, 32'h8000_0000, 32'hffff_ffff, "R9");
    // R5 R7 left shifts
    apply(6'h00, 6'h00, 5'd4, 32'h0005_4321, 32'hbad0_bad0, "R5");
    apply(6'h00, 6'h00, 5'd1, 32'h8000_0001, 32'h0, "R7");
    apply(6'h00, 6'h00, 5'd31, 32'hffff_ffff, 32'h0, "R11");
    apply(6'h00, 6'h00, 5'd0, 32'h1357_9bdf, 32'h0, "R11");
    // R6 R8 right shifts, sign bit set to catch arithmetic fill
    apply(6'h00, 6'h02, 5'd4, 32'hf000_0000, 32'h0, "R6");
    apply(6'h00, 6'h02, 5'd1, 32'h8000_0001, 32'h5, "R8");
    apply(6'h00, 6'h02, 5'd31, 32'hffff_ffff, 32'h0, "R11");
    apply(6'h00, 6'h02, 5'd0, 32'hfedc_ba98, 32'h0, "R11");
    // R10 undefined R-type functions and opcodes
    apply(6'h00, 6'h03, 5'd4, 32'hffff_ffff, 32'h0000_abcd, "R10");
    apply(6'h00, 6'h01, 5'd8, 32'hffff_ffff, 32'h0000_1234, "R10");
    apply(6'h00, 6'h21, 5'd0, 32'h1, 32'h2, "R10");
    apply(6'h08, 6'h00, 5'd3, 32'h1, 32'h9, "R10");
    apply(6'h22, 6'h20, 5'd3, 32'h1, 32'h9, "R10");
    apply(6'h05, 6'h00, 5'd0, 32'h1, 32'h9, "R10");
    // mixed sweep over counts and data for both shifts (R7 R8)
    for (int i = 0; i < 64; i++) begin
      apply(6'h00, (i % 2 == 0) ? 6'h00 : 6'h02, 5'(i / 2),
            $urandom, $urandom, (i % 2 == 0) ? "R7" : "R8");
    end
    // mixed sweep over non-shift rows (R9)
    for (int i = 0; i < 32; i++) begin
      apply((i % 4 == 0) ? 6'h23 : (i % 4 == 1) ? 6'h2b :
            (i % 4 == 2) ? 6'h04 : 6'h00,
            (i % 4 == 3) ? 6'h25 : 6'h00, 5'($urandom),
            $urandom, $urandom, "R9");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule